// File: doc/BRIEF.md
# Preamble DC Level Detector

This block sits behind an envelope demodulator in an on-off-keyed receiver. During the opening run of alternating ones and zeros in a preamble, it estimates the DC level of the demodulated 16-bit signed stream. It does this with a sliding average taken over the last 32 accepted samples. At eight samples per bit, that window spans four bit periods, so equal numbers of high and low samples cancel to the mid level.

A two-stage qualification decides when a real signal is present. First, each average is compared with a programmable amplitude threshold. Second, the number of averages above that threshold is counted against a programmable count threshold. When the count reaches its threshold, the block raises a correlation-enable flag and, on the same clock edge, stores the average into a DC level register. Downstream correlation logic subtracts that stored level before matched filtering.

Once enabled, the flag and the stored level hold until an asynchronous reset or a synchronous clear.

The sample input is a valid/ready stream. Ready is high in every cycle out of reset, so the block never applies back-pressure. A sample is accepted in any cycle where valid and ready are both high; cycles without valid change nothing.

Top module: `ook_dc_level_det`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, and in the first cycle after it is released, `corr_en` is 0 and `dc_level` is 0. `in_ready` is 1 from the first clock edge after reset release onward.
- R2: The running average is the arithmetic (floor) quotient of the signed sum of the 32 most recently accepted samples divided by 32. This is bits 20 down to 5 of a 21-bit accumulator.
- R3: No comparison is made until 32 samples have been accepted since reset or clear. The earliest enabling sample is therefore the 33rd, and it is judged on the average of samples 1 to 32.
- R4: An accepted sample counts as valid only if the average, taken before that sample enters the window, is strictly greater than the signed `amp_thr`. An average equal to `amp_thr` does not count.
- R5: Valid samples are counted whether or not they are consecutive. `corr_en` rises after the clock edge of the accepted sample at which the count reaches `cnt_thr`. A `cnt_thr` of 0 behaves as 1.
- R6: On the edge where `corr_en` rises, `dc_level` takes the average that was compared at that sample. While `corr_en` is 0, `dc_level` stays 0.
- R7: Once `corr_en` is 1, it stays 1 and `dc_level` does not change, whatever samples or thresholds follow, until reset or clear.
- R8: A high `clear` at a clock edge returns the block to its reset state, including the sample window, so warm-up restarts. A sample offered in the same cycle as `clear` is discarded.
- R9: Cycles with `in_valid` low change neither the window, the count, `corr_en` nor `dc_level`.
- R10: `in_ready` stays 1 in every cycle out of reset, including while `clear` is high or `corr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Synchronous restart of the detector |
| in_valid | input | 1 | Sample stream valid |
| in_ready | output | 1 | Sample stream ready, always 1 out of reset |
| in_data | input | 16 | Signed demodulated envelope sample |
| amp_thr | input | 16 | Signed amplitude threshold for the average |
| cnt_thr | input | 8 | Number of above-threshold averages needed |
| corr_en | output | 1 | Correlation enable, sticky |
| dc_level | output | 16 | Stored signed DC level |

## Verification
Two events can land on the same clock edge: the accepted sample whose average completes the count, and a `clear`. The bench drives `clear` together with a valid sample that would otherwise enable the block. It expects `corr_en` and `dc_level` to read 0 afterwards, and then expects a full fresh 32-sample warm-up before the block can enable again. A second coincidence is the end of warm-up meeting the first comparison. Samples are streamed back to back, so the 33rd accepted sample can enable the block. The bench's arithmetic model predicts the exact sample index and the stored level for each of these cases.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  // Detector phase: filling the window, seeking a stable signal, locked.
  typedef enum logic [1:0] {
    PH_FILL = 2'd0,
    PH_SEEK = 2'd1,
    PH_LOCK = 2'd2
  } dcd_phase_e;

  // Effective count threshold: zero is treated as one.
  function automatic logic [7:0] eff_thr8(input logic [7:0] thr);
    return (thr == 8'd0) ? 8'd1 : thr;
  endfunction

endpackage

// File: rtl/dcd_window.sv
// Sliding-sum window: circular sample store plus running accumulator.
module dcd_window #(
  parameter int SW        = 16,
  parameter int TAPS_LOG2 = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          strobe,
  input  logic [SW-1:0] din,
  output logic [SW-1:0] avg,
  output logic          warm
);
  localparam int TAPS = 1 << TAPS_LOG2;
  localparam int AW   = SW + TAPS_LOG2;
  localparam int FW   = TAPS_LOG2 + 1;

  logic [SW-1:0]        mem [TAPS];
  logic [TAPS_LOG2-1:0] wr_ptr;
  logic [FW-1:0]        fill;
  logic [AW-1:0]        acc;
  logic [AW-1:0]        ext_new;
  logic [AW-1:0]        ext_old;
  logic [SW-1:0]        oldest;

  assign warm    = (fill == FW'(TAPS));
  assign oldest  = mem[wr_ptr];
  assign ext_new = {{TAPS_LOG2{din[SW-1]}}, din};
  // Only subtract a departing sample once the window is full.
  assign ext_old = warm ? {{TAPS_LOG2{oldest[SW-1]}}, oldest} : '0;
  assign avg     = acc[AW-1 -: SW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) mem[k] <= '0;
    end else if (clear) begin
      for (int k = 0; k < TAPS; k++) mem[k] <= '0;
    end else if (strobe) begin
      mem[wr_ptr] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill   <= '0;
      acc    <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      fill   <= '0;
      acc    <= '0;
    end else if (strobe) begin
      wr_ptr <= wr_ptr + 1'b1;
      acc    <= acc + ext_new - ext_old;
      if (!warm) fill <= fill + 1'b1;
    end
  end

endmodule

// File: rtl/dcd_qualify.sv
// Amplitude comparator followed by a saturating count of valid averages.
module dcd_qualify #(
  parameter int SW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          eval,
  input  logic [SW-1:0] avg,
  input  logic [SW-1:0] amp_thr,
  input  logic [CW-1:0] cnt_thr,
  output logic          hit
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] eff;
  logic [CW:0]   nxt;
  logic          above;
  logic          reach;

  assign above = $signed(avg) > $signed(amp_thr);
  assign eff   = (cnt_thr == '0) ? CW'(1) : cnt_thr;
  assign nxt   = {1'b0, cnt} + 1'b1;
  assign reach = (nxt >= {1'b0, eff});
  assign hit   = eval && above && reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (eval && above) begin
      cnt <= reach ? eff : nxt[CW-1:0];
    end
  end

endmodule

// File: rtl/dcd_ctrl.sv
// Phase control, sticky enable and one-time capture of the DC level.
module dcd_ctrl
  import dcd_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          warm,
  input  logic          hit,
  input  logic [SW-1:0] avg,
  output logic          locked,
  output logic [SW-1:0] dc_q
);
  dcd_phase_e phase;

  assign locked = (phase == PH_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_FILL;
      dc_q  <= '0;
    end else if (clear) begin
      phase <= PH_FILL;
      dc_q  <= '0;
    end else begin
      case (phase)
        PH_FILL: begin
          if (hit) begin
            phase <= PH_LOCK;
            dc_q  <= avg;
          end else if (warm) begin
            phase <= PH_SEEK;
          end
        end
        PH_SEEK: begin
          if (hit) begin
            phase <= PH_LOCK;
            dc_q  <= avg;
          end
        end
        default: phase <= PH_LOCK;
      endcase
    end
  end

endmodule

// File: rtl/ook_dc_level_det.sv
module ook_dc_level_det #(
  parameter int SW        = 16,
  parameter int TAPS_LOG2 = 5,
  parameter int CW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_data,
  input  logic [SW-1:0] amp_thr,
  input  logic [CW-1:0] cnt_thr,
  output logic          corr_en,
  output logic [SW-1:0] dc_level
);
  logic          ready_q;
  logic          strobe;
  logic          eval;
  logic          warm;
  logic          hit;
  logic          locked;
  logic [SW-1:0] avg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign strobe   = in_valid && ready_q && !clear;
  assign eval     = strobe && warm && !locked;

  dcd_window #(.SW(SW), .TAPS_LOG2(TAPS_LOG2)) u_window (
    .clk(clk), .rst_n(rst_n), .clear(clear), .strobe(strobe),
    .din(in_data), .avg(avg), .warm(warm)
  );

  dcd_qualify #(.SW(SW), .CW(CW)) u_qualify (
    .clk(clk), .rst_n(rst_n), .clear(clear), .eval(eval),
    .avg(avg), .amp_thr(amp_thr), .cnt_thr(cnt_thr), .hit(hit)
  );

  dcd_ctrl #(.SW(SW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .warm(warm),
    .hit(hit), .avg(avg), .locked(locked), .dc_q(dc_level)
  );

  assign corr_en = locked;

endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
  parameter int SW        = 16,
  parameter int TAPS_LOG2 = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          in_valid,
  input logic          in_ready,
  input logic          corr_en,
  input logic [SW-1:0] dc_level
);
  localparam int TAPS = 1 << TAPS_LOG2;
  localparam int NW   = TAPS_LOG2 + 2;

  // Accepted samples since reset or clear, saturating just past the window.
  logic [NW-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                         seen_q <= '0;
    else if (clear)                                     seen_q <= '0;
    else if (in_valid && in_ready && seen_q <= NW'(TAPS)) seen_q <= seen_q + 1'b1;
  end

  p_warmup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    corr_en |-> (seen_q > NW'(TAPS)));

  p_needs_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!corr_en && !(in_valid && in_ready)) |=> !corr_en);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_en && !clear) |=> corr_en);

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_en && !clear) |=> $stable(dc_level));

  p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_en |-> (dc_level == '0));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!corr_en && dc_level == '0));

endmodule

bind ook_dc_level_det dcd_checker #(.SW(SW), .TAPS_LOG2(TAPS_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
  .in_ready(in_ready), .corr_en(corr_en), .dc_level(dc_level)
);

// File: tb/ook_dc_level_det_test.sv
module ook_dc_level_det_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [15:0] amp_thr = '0;
  logic [7:0]  cnt_thr = '0;
  logic        corr_en;
  logic [15:0] dc_level;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // Reference model state
  int  m_hist [32];
  int  m_fill, m_hp, m_sum, m_cnt, m_dc, m_amp, m_eff;
  bit  m_en;

  always #4 clk = ~clk;

  ook_dc_level_det uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .amp_thr(amp_thr),
    .cnt_thr(cnt_thr), .corr_en(corr_en), .dc_level(dc_level)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 32; k++) m_hist[k] = 0;
    m_fill = 0; m_hp = 0; m_sum = 0; m_cnt = 0; m_en = 0; m_dc = 0;
  endtask

  task automatic model_step(input int x);
    int a;
    if (m_fill == 32) begin
      a = m_sum >>> 5;
      if (!m_en) begin
        if (a > m_amp) m_cnt++;
        if (m_cnt >= m_eff) begin m_en = 1; m_dc = a; end
      end
      m_sum -= m_hist[m_hp];
    end
    m_sum += x;
    m_hist[m_hp] = x;
    m_hp = (m_hp + 1) % 32;
    if (m_fill < 32) m_fill++;
  endtask

  task automatic compare(input string tag);
    chk({tag, " R5 enable"}, int'(corr_en), int'(m_en));
    chk({tag, " R6 level"}, int'($signed(dc_level)), m_dc);
  endtask

  task automatic set_thr(input int amp, input int ct);
    amp_thr = 16'(amp);
    cnt_thr = 8'(ct);
    m_amp = amp;
    m_eff = (ct == 0) ? 1 : ct;
  endtask

  // One accepted sample; outputs sampled at the following falling edge.
  task automatic push(input int x, input string tag);
    in_valid = 1'b1;
    in_data  = 16'(x);
    @(negedge clk);
    in_valid = 1'b0;
    model_step(x);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      in_data = 16'h7fff;
      @(negedge clk);
      compare(tag);
    end
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model_clear();
    chk("R8 clear enable", int'(corr_en), 0);
    chk("R8 clear level", int'(dc_level), 0);
  endtask

  function automatic int pat(input int p, input int i);
    case (p)
      0: return (((i / 8) % 2) == 0 ? 1200 : 100) + ((i * 37) % 17) - 8;
      1: return (((i / 8) % 2) == 0 ? 2500 : -300) + ((i * 53) % 29) - 14;
      default: return ((i * 29) % 61) - 30;
    endcase
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int amps [4];
    int cts [6];
    amps = '{-100, 0, 500, 1100};
    cts  = '{0, 1, 2, 3, 5, 8};
    model_clear();
    set_thr(0, 1);
    @(negedge clk);
    chk("R1 reset enable", int'(corr_en), 0);
    chk("R1 reset level", int'(dc_level), 0);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 enable after release", int'(corr_en), 0);
    @(negedge clk);
    chk("R1 ready", int'(in_ready), 1);

    // R3: warm-up, earliest enable at the 33rd sample
    set_thr(-32768, 1);
    do_clear();
    for (int i = 0; i < 32; i++) push(20000, "R3 warmup");
    chk("R3 low after 32", int'(corr_en), 0);
    push(20000, "R3 first compare");
    chk("R3 enabled at 33", int'(corr_en), 1);
    chk("R2 level of constant", int'($signed(dc_level)), 20000);

    // R7: locked state ignores later samples and threshold changes
    for (int i = 0; i < 40; i++) push(-30000, "R7 after lock");
    set_thr(32767, 200);
    idle(2, "R7 thr change");
    chk("R7 level frozen", int'($signed(dc_level)), 20000);
    chk("R7 still enabled", int'(corr_en), 1);

    // R4: equality does not count; one below does
    set_thr(320, 1);
    do_clear();
    for (int i = 0; i < 40; i++) push(320, "R4 equal");
    chk("R4 equal never enables", int'(corr_en), 0);
    set_thr(319, 1);
    push(320, "R4 just above");
    chk("R4 above enables", int'(corr_en), 1);
    chk("R4 level", int'($signed(dc_level)), 320);

    // R2: floor for negative sums (31 x -1 plus one 0 -> -31/32 -> -1)
    set_thr(-32768, 1);
    do_clear();
    push(0, "R2 neg");
    for (int i = 0; i < 31; i++) push(-1, "R2 neg");
    push(5, "R2 neg");
    chk("R2 floor of negative", int'($signed(dc_level)), -1);

    // R8: clear collides with the sample that would enable
    set_thr(-32768, 1);
    do_clear();
    for (int i = 0; i < 32; i++) push(20000, "R8 prefill");
    in_valid = 1'b1; in_data = 16'd20000; clear = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; clear = 1'b0;
    model_clear();
    chk("R8 collision enable", int'(corr_en), 0);
    chk("R8 collision level", int'(dc_level), 0);
    chk("R10 ready after clear", int'(in_ready), 1);
    for (int i = 0; i < 32; i++) push(20000, "R8 refill");
    chk("R8 warmup restarted", int'(corr_en), 0);
    idle(5, "R9 idle before enable");
    chk("R9 idle no enable", int'(corr_en), 0);
    push(20000, "R8 enable after refill");
    chk("R8 enable after refill", int'(corr_en), 1);

    // Sweep: patterns x amplitude thresholds x count thresholds
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < 4; a++)
        for (int c = 0; c < 6; c++) begin
          set_thr(amps[a], cts[c]);
          do_clear();
          for (int i = 0; i < 64; i++) begin
            push(pat(p, i), "sweep");
            if (p == 1 && (i % 3) == 2) idle(2, "R9 gap");
          end
          chk("R10 ready in sweep", int'(in_ready), 1);
        end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule